// File: doc/BRIEF.md
# SPI-Addressed Eight-Pin GPIO Expander

This block gives a host eight general-purpose pins through a mode-0 SPI slave port. Every transaction is framed by chip select. The first byte is an opcode that names the device and the direction of transfer. The second byte sets a register pointer. The bytes after that are either written into the register bank or shifted out of it on MISO. A bank of eleven byte-wide registers holds the following:

- pin direction
- input polarity
- change-interrupt enables
- a compare value
- compare mode
- configuration
- pull-up enables
- interrupt flags
- captured port value
- the port itself
- the output latch

Up to four of these expanders can sit on one chip select. Each one is strapped to a two-bit hardware address. Matching on that address is enabled by a configuration bit. The serial inputs and the pins are oversampled by the system clock through synchronisers, so SCK must stay well below the system clock rate. MISO is given as a data bit plus an output enable, and so is the interrupt pin, so that the pad ring can build tri-state or open-drain drivers.

The SPI side has no valid/ready handshake and applies no back-pressure. The master sets the pace through SCK, and the block must finish each byte action within the half SCK period that follows the byte.

Top module: `gpx_spi_expander`

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 0x00), `pin_out` = 0x00, `pull_en` = 0x00, `spi_miso_oe` = 0, and the interrupt output is driven inactive (`irq_oe` = 1, `irq_out` = 1).
- R2: A frame starts with an opcode byte laid out as 0100 in bits 7:4, a device address in bits 2:1 and a direction flag in bit 0 (1 = read). A register address byte follows, then data bytes. Register addresses are: 0x00 direction, 0x01 polarity, 0x02 change-interrupt enable, 0x03 compare value, 0x04 compare mode, 0x05 configuration, 0x06 pull-up, 0x07 flags, 0x08 capture, 0x09 port, 0x0A output latch.
- R3: The direction register drives `pin_oe` as its inverse (a 1 bit means input). The output latch drives `pin_out`. The pull-up register drives `pull_en`. A write to the port register updates the output latch.
- R4: Reading the port register returns each synchronised pin level XORed with its polarity bit. Reading the output latch returns the latched value, whatever the pin levels are.
- R5: While configuration bit 5 is 0, the register pointer advances after every data byte. It wraps from 0x0A back to 0x00.
- R6: While configuration bit 5 is 1, the pointer holds, so every data byte of a frame accesses the same register.
- R7: While configuration bit 3 is 0, the address bits of the opcode are ignored. While it is 1, only a frame whose opcode bits 2:1 equal `hw_addr` is served.
- R8: A frame whose opcode bits 7:4 are not 0100, or whose address does not match while matching is enabled, changes no register and keeps `spi_miso_oe` low until chip select rises.
- R9: Writes to the flag (0x07) and capture (0x08) registers are ignored. Addresses above 0x0A read as 0x00 and ignore writes.
- R10: A pin with its change-interrupt bit set raises its flag in either of two cases. With its compare-mode bit at 0, it raises the flag when its level differs from the previous sample. With the compare-mode bit at 1, it raises the flag when its level differs from the compare value. When flags go from none to some, the capture register takes the port value. Reading the port register clears all flags.
- R11: With configuration bit 2 set, the interrupt output is open-drain: `irq_out` = 0, and `irq_oe` = 1 only while any flag is set. Otherwise `irq_oe` = 1, and `irq_out` shows the flag state as active-high when configuration bit 1 is 1 and as active-low when it is 0.
- R12: Raising chip select in the middle of a byte discards the partial byte. The next frame starts again at the opcode byte.
- R13: Read data leaves MSB first. MISO changes only after SCK falling edges, so the master samples it on rising edges. `spi_miso_oe` is high only during the data phase of a served read frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_addr | input | 2 | Strapped device address |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Drive enable for MISO |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| pull_en | output | 8 | Pad pull-up enables |
| irq_out | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin drive enable |

## Verification
A corrupted register pointer shows up within one frame. The byte read back, or the pad that changes, belongs to the wrong register, and wrap and hold are checked on multi-byte frames. A frame decoder stuck outside the opcode state, or one that accepts a foreign address, appears on the pads and on `spi_miso_oe` during the very next frame. Interrupt state is watched on `irq_out`/`irq_oe` a few clock cycles after a pin changes and again right after the clearing read. Stale flags or capture values therefore surface before the next SPI frame begins.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int PIN_W     = 8;
  localparam int BYTE_W    = 8;
  localparam int REG_COUNT = 11;
  localparam int PTR_W     = $clog2(REG_COUNT);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(REG_COUNT - 1);
  localparam logic [PTR_W-1:0] PTR_NONE = '1;
  localparam logic [3:0] OPCODE_FIXED = 4'b0100;

  localparam logic [PTR_W-1:0] RA_DIR  = 4'd0;
  localparam logic [PTR_W-1:0] RA_POL  = 4'd1;
  localparam logic [PTR_W-1:0] RA_IEN  = 4'd2;
  localparam logic [PTR_W-1:0] RA_CMPV = 4'd3;
  localparam logic [PTR_W-1:0] RA_CMPM = 4'd4;
  localparam logic [PTR_W-1:0] RA_CFG  = 4'd5;
  localparam logic [PTR_W-1:0] RA_PULL = 4'd6;
  localparam logic [PTR_W-1:0] RA_FLAG = 4'd7;
  localparam logic [PTR_W-1:0] RA_CAPT = 4'd8;
  localparam logic [PTR_W-1:0] RA_PORT = 4'd9;
  localparam logic [PTR_W-1:0] RA_LAT  = 4'd10;

  localparam int CFG_SEQ_HOLD = 5;
  localparam int CFG_ADDR_EN  = 3;
  localparam int CFG_IRQ_OD   = 2;
  localparam int CFG_IRQ_HIGH = 1;

  typedef enum logic [2:0] {
    FS_OPCODE, FS_REGADDR, FS_WDATA, FS_RDATA, FS_SKIP
  } frame_state_e;
endpackage

// File: rtl/gpx_spi_shifter.sv
module gpx_spi_shifter
  import gpx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              cs_active,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] sck_sync, cs_sync, mosi_sync;
  logic                   sck_prev;
  logic                   sck_rise, sck_fall;
  logic [CNT_W-1:0]       bit_cnt;
  logic [BYTE_W-1:0]      tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync  <= '0;
      cs_sync   <= '1;
      mosi_sync <= '0;
      sck_prev  <= 1'b0;
    end else begin
      sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck_i};
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n_i};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_i};
      sck_prev  <= sck_sync[SYNC_STAGES-1];
    end
  end

  assign cs_active = ~cs_sync[SYNC_STAGES-1];
  assign sck_rise  = sck_sync[SYNC_STAGES-1] & ~sck_prev;
  assign sck_fall  = ~sck_sync[SYNC_STAGES-1] & sck_prev;

  // Receive: sample on rising edges, flag a byte after the last bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!cs_active) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        rx_byte   <= {rx_byte[BYTE_W-2:0], mosi_sync[SYNC_STAGES-1]};
        bit_cnt   <= bit_cnt + 1'b1;
        byte_done <= (bit_cnt == CNT_W'(BYTE_W - 1));
      end
    end
  end

  // Transmit: on a falling edge at a byte boundary load, otherwise shift.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
    end else if (cs_active && sck_fall) begin
      if (bit_cnt == '0) tx_sr <= tx_byte;
      else               tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
    end
  end

  assign miso = tx_sr[BYTE_W-1];
endmodule

// File: rtl/gpx_frame_ctrl.sv
module gpx_frame_ctrl
  import gpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [1:0]        hw_addr,
  input  logic              addr_match_en,
  input  logic              seq_hold,
  output logic              wr_en,
  output logic              rd_en,
  output logic [PTR_W-1:0]  acc_addr,
  output logic [PTR_W-1:0]  reg_ptr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              miso_oe
);
  frame_state_e     state;
  logic             is_read;
  logic             op_ok;
  logic [PTR_W-1:0] ptr_step;

  always_comb begin
    op_ok = (rx_byte[7:4] == OPCODE_FIXED) &&
            (!addr_match_en || (rx_byte[2:1] == hw_addr));
    if (seq_hold)                ptr_step = reg_ptr;
    else if (reg_ptr >= PTR_LAST) ptr_step = '0;
    else                          ptr_step = reg_ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= FS_OPCODE;
      is_read  <= 1'b0;
      wr_en    <= 1'b0;
      rd_en    <= 1'b0;
      acc_addr <= '0;
      reg_ptr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      rd_en <= 1'b0;
      if (!cs_active) begin
        state <= FS_OPCODE;
      end else if (byte_done) begin
        unique case (state)
          FS_OPCODE: begin
            is_read <= rx_byte[0];
            state   <= op_ok ? FS_REGADDR : FS_SKIP;
          end
          FS_REGADDR: begin
            reg_ptr <= (rx_byte < BYTE_W'(REG_COUNT)) ? rx_byte[PTR_W-1:0] : PTR_NONE;
            state   <= is_read ? FS_RDATA : FS_WDATA;
          end
          FS_WDATA: begin
            wr_en    <= 1'b1;
            wr_data  <= rx_byte;
            acc_addr <= reg_ptr;
            reg_ptr  <= ptr_step;
          end
          FS_RDATA: begin
            rd_en    <= 1'b1;
            acc_addr <= reg_ptr;
            reg_ptr  <= ptr_step;
          end
          default: state <= FS_SKIP;
        endcase
      end
    end
  end

  assign miso_oe = cs_active && (state == FS_RDATA);
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  acc_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [BYTE_W-1:0] rd_data,
  output logic [PIN_W-1:0]  dir_q,
  output logic [PIN_W-1:0]  lat_q,
  output logic [PIN_W-1:0]  pull_q,
  output logic [PIN_W-1:0]  flag_q,
  output logic [PIN_W-1:0]  capt_q,
  output logic              seq_hold,
  output logic              addr_match_en,
  output logic              irq_od,
  output logic              irq_high
);
  logic [PIN_W-1:0]  pol_q, ien_q, cmpv_q, cmpm_q;
  logic [BYTE_W-1:0] cfg_q;
  logic [PIN_W-1:0]  pin_sync [SYNC_STAGES];
  logic [PIN_W-1:0]  pin_s, pin_prev, port_val, evt;
  logic              flag_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) pin_sync[s] <= '0;
      pin_prev <= '0;
    end else begin
      pin_sync[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) pin_sync[s] <= pin_sync[s-1];
      pin_prev <= pin_sync[SYNC_STAGES-1];
    end
  end

  assign pin_s    = pin_sync[SYNC_STAGES-1];
  assign port_val = pin_s ^ pol_q;

  // Per-pin change detection against previous sample or compare value.
  for (genvar i = 0; i < PIN_W; i++) begin : g_evt
    logic ref_bit;
    assign ref_bit = cmpm_q[i] ? cmpv_q[i] : pin_prev[i];
    assign evt[i]  = ien_q[i] & (pin_s[i] ^ ref_bit);
  end

  assign flag_clr = rd_en && (acc_addr == RA_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      pol_q  <= '0;
      ien_q  <= '0;
      cmpv_q <= '0;
      cmpm_q <= '0;
      cfg_q  <= '0;
      pull_q <= '0;
      lat_q  <= '0;
      flag_q <= '0;
      capt_q <= '0;
    end else begin
      if (wr_en) begin
        unique case (acc_addr)
          RA_DIR:          dir_q  <= wr_data;
          RA_POL:          pol_q  <= wr_data;
          RA_IEN:          ien_q  <= wr_data;
          RA_CMPV:         cmpv_q <= wr_data;
          RA_CMPM:         cmpm_q <= wr_data;
          RA_CFG:          cfg_q  <= wr_data;
          RA_PULL:         pull_q <= wr_data;
          RA_PORT, RA_LAT: lat_q  <= wr_data;
          default: ;
        endcase
      end
      flag_q <= (flag_clr ? '0 : flag_q) | evt;
      if ((flag_q == '0) && (evt != '0)) capt_q <= port_val;
    end
  end

  always_comb begin
    unique case (rd_ptr)
      RA_DIR:  rd_data = dir_q;
      RA_POL:  rd_data = pol_q;
      RA_IEN:  rd_data = ien_q;
      RA_CMPV: rd_data = cmpv_q;
      RA_CMPM: rd_data = cmpm_q;
      RA_CFG:  rd_data = cfg_q;
      RA_PULL: rd_data = pull_q;
      RA_FLAG: rd_data = flag_q;
      RA_CAPT: rd_data = capt_q;
      RA_PORT: rd_data = port_val;
      RA_LAT:  rd_data = lat_q;
      default: rd_data = '0;
    endcase
  end

  assign seq_hold      = cfg_q[CFG_SEQ_HOLD];
  assign addr_match_en = cfg_q[CFG_ADDR_EN];
  assign irq_od        = cfg_q[CFG_IRQ_OD];
  assign irq_high      = cfg_q[CFG_IRQ_HIGH];
endmodule

// File: rtl/gpx_spi_expander.sv
module gpx_spi_expander
  import gpx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       hw_addr,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             spi_miso_oe,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] pin_out,
  output logic [PIN_W-1:0] pin_oe,
  output logic [PIN_W-1:0] pull_en,
  output logic             irq_out,
  output logic             irq_oe
);
  logic              cs_active, byte_done;
  logic [BYTE_W-1:0] rx_byte, tx_byte, wr_data;
  logic              wr_en, rd_en;
  logic [PTR_W-1:0]  acc_addr, reg_ptr;
  logic [PIN_W-1:0]  dir_q, lat_q, pull_q, flag_q, capt_q;
  logic              seq_hold, addr_match_en, irq_od, irq_high, irq_any;

  gpx_spi_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .cs_n_i(spi_cs_n),
    .mosi_i(spi_mosi), .tx_byte(tx_byte), .cs_active(cs_active),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  gpx_frame_ctrl u_frame (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .byte_done(byte_done),
    .rx_byte(rx_byte), .hw_addr(hw_addr), .addr_match_en(addr_match_en),
    .seq_hold(seq_hold), .wr_en(wr_en), .rd_en(rd_en), .acc_addr(acc_addr),
    .reg_ptr(reg_ptr), .wr_data(wr_data), .miso_oe(spi_miso_oe)
  );

  gpx_regfile #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .acc_addr(acc_addr), .wr_data(wr_data), .rd_ptr(reg_ptr),
    .pin_in(pin_in), .rd_data(tx_byte), .dir_q(dir_q), .lat_q(lat_q),
    .pull_q(pull_q), .flag_q(flag_q), .capt_q(capt_q), .seq_hold(seq_hold),
    .addr_match_en(addr_match_en), .irq_od(irq_od), .irq_high(irq_high)
  );

  assign pin_oe  = ~dir_q;
  assign pin_out = lat_q;
  assign pull_en = pull_q;
  assign irq_any = |flag_q;

  always_comb begin
    if (irq_od) begin
      irq_out = 1'b0;
      irq_oe  = irq_any;
    end else begin
      irq_oe  = 1'b1;
      irq_out = irq_high ? irq_any : ~irq_any;
    end
  end
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker
  import gpx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             spi_cs_n,
  input logic             spi_miso_oe,
  input logic [PIN_W-1:0] pin_oe,
  input logic [PIN_W-1:0] pull_en,
  input logic             wr_en,
  input logic             rd_en,
  input logic [PTR_W-1:0] reg_ptr,
  input logic [PIN_W-1:0] flag_q,
  input logic [PIN_W-1:0] capt_q
);
  // R1: pads come out of reset as inputs with pull-ups off
  a_r1_reset_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0) && (pull_en == '0));

  // R3: direction only moves on a register write
  a_r3_dir_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_oe));

  // R8, R13: MISO undriven once deselect has settled
  a_r8_miso_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
    |-> !spi_miso_oe);

  // R5: pointer stays inside the map or at the out-of-range marker
  a_r5_ptr_in_map: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_ptr <= PTR_LAST) || (reg_ptr == PTR_NONE));

  // R10: capture reloads only when no flag was pending
  a_r10_capture_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(capt_q) |-> ($past(flag_q) == '0));

  // R12: one register action per cycle
  a_r12_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, rd_en}));
endmodule

bind gpx_spi_expander gpx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .pin_oe(pin_oe), .pull_en(pull_en), .wr_en(wr_en), .rd_en(rd_en),
  .reg_ptr(reg_ptr), .flag_q(flag_q), .capt_q(capt_q)
);

// File: tb/gpx_spi_expander_test.sv
module gpx_spi_expander_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HALF = 40;
  localparam logic [1:0] DEV = 2'b10;
  localparam logic [7:0] OPW = 8'h44;  // matching write
  localparam logic [7:0] OPR = 8'h45;  // matching read

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic       spi_miso, spi_miso_oe;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out, pin_oe, pull_en;
  logic       irq_out, irq_oe;

  int vectors = 0;
  int miscompares = 0;
  logic oe_seen;
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];

  always #2.5 clk = ~clk;

  gpx_spi_expander uut (
    .clk(clk), .rst_n(rst_n), .hw_addr(DEV), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pull_en(pull_en), .irq_out(irq_out), .irq_oe(irq_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      #HALF;
      rx[i] = spi_miso;
      oe_seen = oe_seen | spi_miso_oe;
      spi_sck = 1'b1;
      #HALF;
      spi_sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] op, input logic [7:0] addr, input int n);
    logic [7:0] d;
    oe_seen  = 1'b0;
    spi_cs_n = 1'b0;
    #HALF;
    xfer(op, d);
    xfer(addr, d);
    for (int k = 0; k < n; k++) begin
      xfer(wbuf[k], d);
      rbuf[k] = d;
    end
    #HALF;
    spi_cs_n = 1'b1;
    #(4 * HALF);
  endtask

  task automatic wr1(input logic [7:0] op, input logic [7:0] addr, input logic [7:0] v);
    wbuf[0] = v;
    frame(op, addr, 1);
  endtask

  task automatic rd1(input logic [7:0] op, input logic [7:0] addr, output logic [7:0] v);
    wbuf[0] = 8'h00;
    frame(op, addr, 1);
    v = rbuf[0];
  endtask

  task automatic t_reset;
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 pull_en", pull_en, 8'h00);
    chk("R1 miso_oe", {7'd0, spi_miso_oe}, 8'h00);
    chk("R1 irq", {6'd0, irq_oe, irq_out}, 8'h03);
  endtask

  task automatic t_write_pins;
    wr1(8'h40, 8'h00, 8'hF0);
    wr1(8'h46, 8'h0A, 8'hA5);
    wr1(OPW, 8'h06, 8'h3C);
    chk("R2 R3 pin_oe", pin_oe, 8'h0F);
    chk("R3 pin_out", pin_out, 8'hA5);
    chk("R3 pull_en", pull_en, 8'h3C);
  endtask

  task automatic t_read_port_latch;
    logic [7:0] v;
    pin_in = 8'h5A;
    wr1(OPW, 8'h01, 8'h0F);
    rd1(OPR, 8'h0A, v);
    chk("R4 latch readback", v, 8'hA5);
    chk("R13 miso_oe in read data", {7'd0, oe_seen}, 8'h01);
    rd1(OPR, 8'h09, v);
    chk("R4 port xor polarity", v, 8'h55);
  endtask

  task automatic t_sequential;
    logic [7:0] v;
    wbuf[0] = 0; wbuf[1] = 0; wbuf[2] = 0;
    frame(OPR, 8'h0A, 3);
    chk("R5 seq read 0x0A", rbuf[0], 8'hA5);
    chk("R5 wrap to 0x00", rbuf[1], 8'hF0);
    chk("R5 then 0x01", rbuf[2], 8'h0F);
    wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h77;
    frame(OPW, 8'h01, 3);
    rd1(OPR, 8'h03, v);
    chk("R5 seq write third reg", v, 8'h77);
    rd1(OPR, 8'h09, v);
    chk("R5 polarity cleared by seq write", v, 8'h5A);
  endtask

  task automatic t_hw_addr;
    logic [7:0] v;
    wr1(8'h42, 8'h05, 8'h08);           // match disabled: foreign address accepted
    wr1(8'h42, 8'h0A, 8'h11);
    chk("R7 foreign addr ignored", pin_out, 8'hA5);
    rd1(8'h43, 8'h0A, v);
    chk("R8 foreign read keeps miso off", {7'd0, oe_seen}, 8'h00);
    wr1(OPW, 8'h0A, 8'h22);
    chk("R7 own addr served", pin_out, 8'h22);
    wr1(8'h54, 8'h0A, 8'hFF);
    chk("R8 bad fixed bits ignored", pin_out, 8'h22);
    rd1(8'h55, 8'h0A, v);
    chk("R8 bad opcode read keeps miso off", {7'd0, oe_seen}, 8'h00);
  endtask

  task automatic t_seq_hold;
    logic [7:0] v;
    wr1(OPW, 8'h05, 8'h28);
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
    frame(OPW, 8'h0A, 3);
    chk("R6 held pointer last write", pin_out, 8'h03);
    chk("R6 direction untouched", pin_oe, 8'h0F);
    wbuf[0] = 0; wbuf[1] = 0;
    frame(OPR, 8'h0A, 2);
    chk("R6 held read byte0", rbuf[0], 8'h03);
    chk("R6 held read byte1", rbuf[1], 8'h03);
    wr1(OPW, 8'h05, 8'h08);
    rd1(OPR, 8'h05, v);
    chk("R6 config restored", v, 8'h08);
  endtask

  task automatic t_readonly;
    logic [7:0] v;
    wr1(OPW, 8'h07, 8'hFF);
    wr1(OPW, 8'h08, 8'hFF);
    rd1(OPR, 8'h07, v);
    chk("R9 flag write ignored", v, 8'h00);
    rd1(OPR, 8'h08, v);
    chk("R9 capture write ignored", v, 8'h00);
    rd1(OPR, 8'h0C, v);
    chk("R9 beyond map reads zero", v, 8'h00);
  endtask

  task automatic t_interrupt;
    logic [7:0] v;
    wr1(OPW, 8'h04, 8'h00);
    wr1(OPW, 8'h02, 8'h01);
    chk("R10 no flag without change", {6'd0, irq_oe, irq_out}, 8'h03);
    pin_in = 8'h5B;
    #200;
    chk("R10 R11 active-low asserted", {6'd0, irq_oe, irq_out}, 8'h02);
    rd1(OPR, 8'h07, v);
    chk("R10 flag bit0", v, 8'h01);
    rd1(OPR, 8'h08, v);
    chk("R10 capture", v, 8'h5B);
    rd1(OPR, 8'h09, v);
    chk("R10 port read", v, 8'h5B);
    chk("R10 cleared by port read", {6'd0, irq_oe, irq_out}, 8'h03);
    wr1(OPW, 8'h05, 8'h0A);
    chk("R11 active-high idle", {6'd0, irq_oe, irq_out}, 8'h02);
    pin_in = 8'h5A;
    #200;
    chk("R11 active-high asserted", {6'd0, irq_oe, irq_out}, 8'h03);
    wr1(OPW, 8'h05, 8'h0E);
    chk("R11 open-drain pulling", {6'd0, irq_oe, irq_out}, 8'h02);
    rd1(OPR, 8'h09, v);
    chk("R11 open-drain released", {6'd0, irq_oe, irq_out}, 8'h00);
    wr1(OPW, 8'h03, 8'h00);
    wr1(OPW, 8'h04, 8'h01);
    chk("R10 compare match no flag", {6'd0, irq_oe, irq_out}, 8'h00);
    pin_in = 8'h5B;
    #200;
    rd1(OPR, 8'h07, v);
    chk("R10 compare mismatch flag", v, 8'h01);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    spi_cs_n = 1'b0;
    #HALF;
    for (int i = 0; i < 5; i++) begin
      spi_mosi = 1'b1;
      #HALF; spi_sck = 1'b1; #HALF; spi_sck = 1'b0;
    end
    #HALF;
    spi_cs_n = 1'b1;
    #(4 * HALF);
    wr1(OPW, 8'h0A, 8'h66);
    chk("R12 frame after abort", pin_out, 8'h66);
    rd1(OPR, 8'h0A, v);
    chk("R12 R13 readback after abort", v, 8'h66);
  endtask

  initial begin
    #20 rst_n = 1'b1;
    #80;
    t_reset();
    t_write_pins();
    t_read_port_latch();
    t_sequential();
    t_hw_addr();
    t_seq_hold();
    t_readonly();
    t_interrupt();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(150000 * 5);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule